// File: doc/BRIEF.md
# Predicated Vector Execution Unit

This block is a single-issue vector execution stage. It holds eight vector registers of eight 16-bit elements each, four one-bit-per-element flag registers, and a programmable active-length register. Each cycle it can accept one already-decoded vector instruction and apply that operation to every element lane in parallel. No lane depends on the result of any other lane.

Two controls decide which lanes an instruction touches. The active-length register limits work to the leading lanes. An optional flag register (predicate) limits work to the lanes whose flag bit is set. Flag registers are filled by a lane-wise inequality compare, so a compare followed by a predicated add or subtract carries out an if-then on each element without any branch. Observation ports let the surrounding pipeline read any vector register, any flag register and the current length.

Top module: `vec_pred_unit`

## Requirements
- R1: After reset every vector register element and every flag register is zero, the active length reads 8, and `done` is low.
- R2: Opcode 0 (add) writes vs1[i]+vs2[i] modulo 2^16 into vd[i] for each enabled lane. Element i of a register occupies bits 16i+15..16i of `obsVecData`. Lane i of a flag register is bit i.
- R3: Opcode 1 (subtract) writes vs1[i]-vs2[i] modulo 2^16 into vd[i] for each enabled lane.
- R4: Opcode 2 (scalar add) writes vs1[i]+`instScalar` modulo 2^16 into vd[i] for each enabled lane.
- R5: Opcode 3 (compare not-equal) writes flag register `instVd[1:0]`. Bit i is 1 when vs1[i] differs from vs2[i] and i is below the active length. Every bit at or above the active length is written as 0. The compare ignores `instMask`.
- R6: Opcode 4 (set length) loads the active length with `instScalar`. Any value above 8 is clamped to 8. A length of 0 is legal.
- R7: Elements at indices at or above the active length keep their previous value through opcodes 0, 1 and 2.
- R8: When `instMask` is nonzero, opcodes 0, 1 and 2 write only the lanes whose bit is 1 in the named flag register. The other lanes keep their values. An `instMask` of 0 means all lanes are enabled, whatever flag register 0 holds.
- R9: An instruction sampled with `instValid` high updates the state at that clock edge, and `done` is high for exactly the following cycle. With `instValid` low, or with opcodes 5 to 7, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction present this cycle |
| instOp | input | 3 | Opcode: 0 add, 1 sub, 2 scalar add, 3 compare not-equal, 4 set length |
| instVd | input | 3 | Destination vector register; low two bits select the flag register for a compare |
| instVs1 | input | 3 | First source vector register |
| instVs2 | input | 3 | Second source vector register |
| instMask | input | 2 | Predicate flag register, 0 = unpredicated |
| instScalar | input | 16 | Scalar operand or new length |
| done | output | 1 | One-cycle completion pulse |
| obsVecSel | input | 3 | Vector register to observe |
| obsVecData | output | 128 | Contents of the observed vector register |
| obsMaskSel | input | 2 | Flag register to observe |
| obsMaskData | output | 8 | Contents of the observed flag register |
| vlrOut | output | 4 | Current active length |

## Verification
Four properties are checked on every cycle. Any lane that a vector write disables keeps its old value. A compare always leaves zeros above the active length. The length never exceeds the register capacity. The decoded write strobes are never active together. The bench's scenarios are needed for the rest: the values that enabled lanes receive under wrap-around, the exact mask bits a compare produces, clamping of oversized lengths, the distinction between predicate 0 and flag register 0, and the timing of `done` after each instruction.

// File: rtl/vpu_pkg.sv
package vpu_pkg;
  localparam int NUM_VREGS = 8;
  localparam int NUM_MREGS = 4;
  localparam int VSEL_W    = $clog2(NUM_VREGS);
  localparam int MSEL_W    = $clog2(NUM_MREGS);
  localparam int SCALAR_W  = 16;

  typedef enum logic [2:0] {
    OP_VADD   = 3'd0,
    OP_VSUB   = 3'd1,
    OP_VADDS  = 3'd2,
    OP_VCMPNE = 3'd3,
    OP_SETVL  = 3'd4
  } vop_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_e;

  typedef struct packed {
    logic                wrVec;
    logic                wrMask;
    logic                wrVlr;
    alu_e                aluFn;
    logic                useScalar;
    logic [VSEL_W-1:0]   dst;
    logic [VSEL_W-1:0]   srcA;
    logic [VSEL_W-1:0]   srcB;
    logic [MSEL_W-1:0]   predSel;
    logic [MSEL_W-1:0]   maskDst;
    logic [SCALAR_W-1:0] scalar;
  } ctl_t;
endpackage

// File: rtl/vpu_ctrl.sv
module vpu_ctrl
  import vpu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                instValid,
  input  logic [2:0]          instOp,
  input  logic [VSEL_W-1:0]   instVd,
  input  logic [VSEL_W-1:0]   instVs1,
  input  logic [VSEL_W-1:0]   instVs2,
  input  logic [MSEL_W-1:0]   instMask,
  input  logic [SCALAR_W-1:0] instScalar,
  output ctl_t                ctl,
  output logic                done
);
  vop_e opCode;
  assign opCode = vop_e'(instOp);

  always_comb begin
    ctl           = '0;
    ctl.dst       = instVd;
    ctl.srcA      = instVs1;
    ctl.srcB      = instVs2;
    ctl.predSel   = instMask;
    ctl.maskDst   = instVd[MSEL_W-1:0];
    ctl.scalar    = instScalar;
    ctl.aluFn     = ALU_ADD;
    if (instValid) begin
      case (opCode)
        OP_VADD:   ctl.wrVec = 1'b1;
        OP_VSUB: begin
          ctl.wrVec = 1'b1;
          ctl.aluFn = ALU_SUB;
        end
        OP_VADDS: begin
          ctl.wrVec     = 1'b1;
          ctl.useScalar = 1'b1;
        end
        OP_VCMPNE: ctl.wrMask = 1'b1;
        OP_SETVL:  ctl.wrVlr  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= instValid;
  end

  // Only one kind of state is written per instruction (R9)
  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.wrVec, ctl.wrMask, ctl.wrVlr}));
endmodule

// File: rtl/vpu_datapath.sv
module vpu_datapath
  import vpu_pkg::*;
#(
  parameter int ELEMS = 8,
  parameter int EW    = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctl_t                  ctl,
  input  logic [VSEL_W-1:0]     obsVecSel,
  output logic [ELEMS*EW-1:0]   obsVecData,
  input  logic [MSEL_W-1:0]     obsMaskSel,
  output logic [ELEMS-1:0]      obsMaskData,
  output logic [$clog2(ELEMS+1)-1:0] vlrOut
);
  localparam int VLW = $clog2(ELEMS+1);
  localparam logic [VLW-1:0] MAX_VL = VLW'(ELEMS);

  logic [EW-1:0]    vrf [NUM_VREGS][ELEMS];
  logic [ELEMS-1:0] mrf [NUM_MREGS];
  logic [VLW-1:0]   vlr;

  logic [ELEMS-1:0] inLen;
  logic [ELEMS-1:0] predBits;
  logic [ELEMS-1:0] wrEn;
  logic [ELEMS-1:0] neqBits;
  logic [EW-1:0]    laneRes [ELEMS];
  logic [VLW-1:0]   nextVl;

  assign predBits = (ctl.predSel == '0) ? '1 : mrf[ctl.predSel];

  for (genvar i = 0; i < ELEMS; i++) begin : gLane
    logic [EW-1:0] opA;
    logic [EW-1:0] opB;
    assign inLen[i]   = (VLW'(i) < vlr);
    assign wrEn[i]    = ctl.wrVec & inLen[i] & predBits[i];
    assign opA        = vrf[ctl.srcA][i];
    assign opB        = ctl.useScalar ? ctl.scalar[EW-1:0] : vrf[ctl.srcB][i];
    assign laneRes[i] = (ctl.aluFn == ALU_SUB) ? (opA - opB) : (opA + opB);
    assign neqBits[i] = inLen[i] & (vrf[ctl.srcA][i] != vrf[ctl.srcB][i]);
    assign obsVecData[i*EW +: EW] = vrf[obsVecSel][i];

    // A lane left out by length or predicate keeps its value (R7, R8)
    assert_lane_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (ctl.wrVec && !wrEn[i]) |=>
        (vrf[$past(ctl.dst)][i] == $past(vrf[ctl.dst][i])));
  end

  assign nextVl = (ctl.scalar > SCALAR_W'(ELEMS)) ? MAX_VL : ctl.scalar[VLW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_VREGS; r++)
        for (int e = 0; e < ELEMS; e++)
          vrf[r][e] <= '0;
    end else begin
      for (int e = 0; e < ELEMS; e++)
        if (wrEn[e]) vrf[ctl.dst][e] <= laneRes[e];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < NUM_MREGS; m++) mrf[m] <= '0;
    end else if (ctl.wrMask) begin
      mrf[ctl.maskDst] <= neqBits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            vlr <= MAX_VL;
    else if (ctl.wrVlr) vlr <= nextVl;
  end

  assign obsMaskData = mrf[obsMaskSel];
  assign vlrOut      = vlr;

  // Compare leaves no set bit at or above the active length (R5)
  assert_cmp_tail_R5: assert property (@(posedge clk) disable iff (rst)
    ctl.wrMask |=> ((mrf[$past(ctl.maskDst)] >> $past(vlr)) == '0));

  // Active length never exceeds register capacity (R6)
  assert_vlr_max_R6: assert property (@(posedge clk) disable iff (rst)
    vlr <= MAX_VL);
endmodule

// File: rtl/vec_pred_unit.sv
module vec_pred_unit
  import vpu_pkg::*;
#(
  parameter int ELEMS = 8,
  parameter int EW    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       instValid,
  input  logic [2:0]                 instOp,
  input  logic [VSEL_W-1:0]          instVd,
  input  logic [VSEL_W-1:0]          instVs1,
  input  logic [VSEL_W-1:0]          instVs2,
  input  logic [MSEL_W-1:0]          instMask,
  input  logic [SCALAR_W-1:0]        instScalar,
  output logic                       done,
  input  logic [VSEL_W-1:0]          obsVecSel,
  output logic [ELEMS*EW-1:0]        obsVecData,
  input  logic [MSEL_W-1:0]          obsMaskSel,
  output logic [ELEMS-1:0]           obsMaskData,
  output logic [$clog2(ELEMS+1)-1:0] vlrOut
);
  ctl_t ctlBus;

  vpu_ctrl uCtrl (
    .clk(clk), .rst(rst), .instValid(instValid), .instOp(instOp),
    .instVd(instVd), .instVs1(instVs1), .instVs2(instVs2),
    .instMask(instMask), .instScalar(instScalar),
    .ctl(ctlBus), .done(done)
  );

  vpu_datapath #(.ELEMS(ELEMS), .EW(EW)) uDp (
    .clk(clk), .rst(rst), .ctl(ctlBus),
    .obsVecSel(obsVecSel), .obsVecData(obsVecData),
    .obsMaskSel(obsMaskSel), .obsMaskData(obsMaskData),
    .vlrOut(vlrOut)
  );
endmodule

// File: tb/tb_vec_pred_unit.sv
`timescale 1ns/1ps
module tb_vec_pred_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0;
  logic [2:0] instOp = '0, instVd = '0, instVs1 = '0, instVs2 = '0;
  logic [1:0] instMask = '0;
  logic [15:0] instScalar = '0;
  logic done;
  logic [2:0] obsVecSel = '0;
  logic [127:0] obsVecData;
  logic [1:0] obsMaskSel = '0;
  logic [7:0] obsMaskData;
  logic [3:0] vlrOut;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vec_pred_unit dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instOp(instOp),
    .instVd(instVd), .instVs1(instVs1), .instVs2(instVs2),
    .instMask(instMask), .instScalar(instScalar), .done(done),
    .obsVecSel(obsVecSel), .obsVecData(obsVecData),
    .obsMaskSel(obsMaskSel), .obsMaskData(obsMaskData), .vlrOut(vlrOut)
  );

  // Reference state derived from the requirements
  logic [15:0] mv [8][8];
  logic [7:0]  mm [4];
  int          vl;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  vd;
    logic [2:0]  vs1;
    logic [2:0]  vs2;
    logic [1:0]  msk;
    logic [15:0] sc;
    logic [3:0]  req;
  } stim_t;

  localparam int NSTIM = 22;
  localparam stim_t PROG [NSTIM] = '{
    '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd8,     4'd6},
    '{3'd2, 3'd1, 3'd1, 3'd0, 2'd0, 16'd3,     4'd4},
    '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd4,     4'd6},
    '{3'd2, 3'd1, 3'd1, 3'd0, 2'd0, 16'h1000,  4'd7},
    '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd8,     4'd6},
    '{3'd2, 3'd2, 3'd0, 3'd0, 2'd0, 16'hFFFF,  4'd4},
    '{3'd0, 3'd3, 3'd1, 3'd2, 2'd0, 16'd0,     4'd2},
    '{3'd1, 3'd4, 3'd1, 3'd2, 2'd0, 16'd0,     4'd3},
    '{3'd1, 3'd5, 3'd0, 3'd1, 2'd0, 16'd0,     4'd3},
    '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd2,     4'd6},
    '{3'd2, 3'd6, 3'd6, 3'd0, 2'd0, 16'd3,     4'd7},
    '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd8,     4'd6},
    '{3'd3, 3'd1, 3'd6, 3'd7, 2'd0, 16'd0,     4'd5},
    '{3'd3, 3'd2, 3'd1, 3'd0, 2'd0, 16'd0,     4'd5},
    '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd5,     4'd6},
    '{3'd3, 3'd2, 3'd6, 3'd0, 2'd1, 16'd0,     4'd5},
    '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd8,     4'd6},
    '{3'd0, 3'd3, 3'd1, 3'd1, 2'd1, 16'd0,     4'd8},
    '{3'd1, 3'd4, 3'd4, 3'd2, 2'd3, 16'd0,     4'd8},
    '{3'd2, 3'd1, 3'd1, 3'd0, 2'd2, 16'd1,     4'd8},
    '{3'd3, 3'd3, 3'd1, 3'd3, 2'd0, 16'd0,     4'd5},
    '{3'd0, 3'd7, 3'd7, 3'd1, 2'd0, 16'd0,     4'd8}
  };

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [127:0] modelVec(input int r);
    logic [127:0] v;
    for (int e = 0; e < 8; e++) v[e*16 +: 16] = mv[r][e];
    return v;
  endfunction

  task automatic modelApply(input stim_t s);
    logic [15:0] a [8];
    logic [15:0] b [8];
    logic [7:0]  p;
    logic [7:0]  f;
    for (int e = 0; e < 8; e++) begin
      a[e] = mv[s.vs1][e];
      b[e] = mv[s.vs2][e];
    end
    p = (s.msk == 2'd0) ? 8'hFF : mm[s.msk];
    case (s.op)
      3'd0, 3'd1, 3'd2:
        for (int e = 0; e < 8; e++)
          if (e < vl && p[e])
            mv[s.vd][e] = (s.op == 3'd0) ? 16'(a[e] + b[e]) :
                          (s.op == 3'd1) ? 16'(a[e] - b[e]) :
                                           16'(a[e] + s.sc);
      3'd3: begin
        f = '0;
        for (int e = 0; e < 8; e++) f[e] = (e < vl) && (a[e] != b[e]);
        mm[s.vd[1:0]] = f;
      end
      3'd4: vl = (s.sc > 16'd8) ? 8 : int'(s.sc);
      default: ;
    endcase
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drives one instruction; returns the value of done just after the edge
  task automatic issue(input stim_t s, input bit valid, output logic doneSeen);
    @(negedge clk);
    instOp = s.op; instVd = s.vd; instVs1 = s.vs1; instVs2 = s.vs2;
    instMask = s.msk; instScalar = s.sc; instValid = valid;
    @(posedge clk);
    #1;
    doneSeen = done;
    instValid = 1'b0;
    instOp = 3'd0;
  endtask

  task automatic checkVec(input int r, input string req, input string what);
    obsVecSel = 3'(r);
    #0.5;
    check(obsVecData === modelVec(r), req, what, obsVecData, modelVec(r));
  endtask

  task automatic checkAllState(input string req, input string what);
    for (int r = 0; r < 8; r++) checkVec(r, req, what);
    for (int m = 0; m < 4; m++) begin
      obsMaskSel = 2'(m);
      #0.5;
      check(obsMaskData === mm[m], req, {what, " mask"}, 128'(obsMaskData), 128'(mm[m]));
    end
    check(vlrOut === 4'(vl), req, {what, " length"}, 128'(vlrOut), 128'(vl));
  endtask

  task automatic runStim(input stim_t s, input bit valid);
    logic d;
    issue(s, valid, d);
    if (valid) modelApply(s);
    check(d === valid, "R9", "done after instruction", 128'(d), 128'(valid));
    @(posedge clk);
    #1;
    check(done === 1'b0, "R9", "done is one cycle wide", 128'(done), 128'(0));
    case (s.op)
      3'd0, 3'd1, 3'd2: checkVec(int'(s.vd), reqName(s.req), "destination vector");
      3'd3: begin
        obsMaskSel = s.vd[1:0];
        #0.5;
        check(obsMaskData === mm[s.vd[1:0]], reqName(s.req), "compare mask",
              128'(obsMaskData), 128'(mm[s.vd[1:0]]));
      end
      3'd4: check(vlrOut === 4'(vl), reqName(s.req), "active length",
                  128'(vlrOut), 128'(vl));
      default: ;
    endcase
  endtask

  initial begin : watchdog
    #500000;
    fails++;
    checks++;
    $display("FAIL R9 watchdog expired: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    stim_t s;
    for (int r = 0; r < 8; r++)
      for (int e = 0; e < 8; e++) mv[r][e] = '0;
    for (int m = 0; m < 4; m++) mm[m] = '0;
    vl = 8;

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #0.5;
    // R1: reset state
    check(done === 1'b0, "R1", "done after reset", 128'(done), 128'(0));
    checkAllState("R1", "reset state");

    // Table walk
    for (int k = 0; k < NSTIM; k++) runStim(PROG[k], 1'b1);

    // R3: hand-worked wrap value, 0 - 0x1003
    obsVecSel = 3'd5;
    #0.5;
    check(obsVecData[15:0] === 16'hEFFD, "R3", "subtract wraps lane 0",
          128'(obsVecData[15:0]), 128'(16'hEFFD));
    // R2: 0x1003 + 0xFFFF wraps to 0x1002 in v3 before predicated add? v3 lane 4 untouched by masked add
    obsVecSel = 3'd3;
    #0.5;
    check(obsVecData[4*16 +: 16] === 16'h0002, "R2", "add wraps lane 4",
          128'(obsVecData[4*16 +: 16]), 128'(16'h0002));
    // R8: predicated add wrote only lanes 0 and 1 (flag register 1 = 0x03)
    check(obsVecData[15:0] === 16'h2006, "R8", "predicated lane 0 written",
          128'(obsVecData[15:0]), 128'(16'h2006));
    check(obsVecData[2*16 +: 16] === 16'h1002, "R8", "predicated lane 2 kept",
          128'(obsVecData[2*16 +: 16]), 128'(16'h1002));
    // R5: compare with length 5 cleared the upper bits of flag register 2
    obsMaskSel = 2'd2;
    #0.5;
    check(obsMaskData === 8'h03, "R5", "compare tail cleared",
          128'(obsMaskData), 128'(8'h03));

    // R9: instValid low has no effect
    s = '{3'd2, 3'd0, 3'd0, 3'd0, 2'd0, 16'h1234, 4'd9};
    runStim(s, 1'b0);
    checkAllState("R9", "idle cycle");
    // R9: undefined opcode has no effect but completes
    s = '{3'd6, 3'd0, 3'd1, 3'd2, 2'd0, 16'h0007, 4'd9};
    runStim(s, 1'b1);
    checkAllState("R9", "undefined opcode");

    // R6: oversized length clamps to 8
    s = '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd100, 4'd6};
    runStim(s, 1'b1);
    check(vlrOut === 4'd8, "R6", "clamped length", 128'(vlrOut), 128'(8));
    // R6/R7: zero length writes no lane
    s = '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd0, 4'd6};
    runStim(s, 1'b1);
    s = '{3'd2, 3'd7, 3'd7, 3'd0, 2'd0, 16'd1, 4'd7};
    runStim(s, 1'b1);
    checkAllState("R7", "zero length add");
    // R5: compare at zero length writes all zeros
    s = '{3'd3, 3'd1, 3'd1, 3'd0, 2'd0, 16'd0, 4'd5};
    runStim(s, 1'b1);
    check(obsMaskData === 8'h00, "R5", "zero length compare",
          128'(obsMaskData), 128'(8'h00));
    // R8: predicate 0 is all lanes even though flag register 0 holds zero
    s = '{3'd4, 3'd0, 3'd0, 3'd0, 2'd0, 16'd8, 4'd6};
    runStim(s, 1'b1);
    s = '{3'd2, 3'd6, 3'd0, 3'd0, 2'd0, 16'h00AA, 4'd8};
    runStim(s, 1'b1);
    obsVecSel = 3'd6;
    #0.5;
    check(obsVecData === {8{16'h00AA}}, "R8", "unpredicated fills all lanes",
          obsVecData, {8{16'h00AA}});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule